// File: doc/BRIEF.md
# Fixed Off-Time Mixed-Decay Chopping Timer

This block times the current chopping of one H-bridge. It runs on the external oscillator clock. When a drive request arrives it switches the source side on and masks the current-trip comparator for a short programmed window, so that switching transients cannot end the on-phase early. After that window, the first trip ends the on-phase and starts a fixed off-time. During the off-time the block reports whether the bridge should recirculate in fast decay or in slow decay.

In mixed mode the off-time begins with a programmed fast-decay stretch and ends in slow decay. If the fast-decay stretch is as long as the off-time or longer, the whole off-time is fast decay. In slow-only mode the whole off-time is slow decay. When the off-time expires, the source side turns back on and a fresh masking window starts. Dropping the drive request stops everything at once.

Each duration is a short code scaled to oscillator cycles. The off-time and fast-decay codes map to lengths of the form 8·(code+1)−1 cycles. The blanking code selects one of four fixed window lengths.

Top module: `chop_pwm_timer`

## Requirements
- R1: While reset is asserted, src_en_o, blank_o, fast_decay_o and slow_decay_o are all low. After reset they stay low for as long as drive_req_i is low.
- R2: One cycle after drive_req_i is sampled high in the idle state, src_en_o and blank_o go high. blank_o then stays high for exactly 4, 6, 12 or 24 cycles for blank_code_i = 0, 1, 2 or 3.
- R3: trip_i has no effect while blank_o is high: src_en_o stays high and the window keeps its full length.
- R4: A trip sampled while src_en_o is high and blank_o is low makes src_en_o low on the next cycle, and the off-time starts in that same cycle.
- R5: The off-time, during which exactly one of fast_decay_o and slow_decay_o is high, lasts 8·(n+1)−1 cycles, where n is off_code_i read as unsigned.
- R6: In mixed mode (slow_only_i = 0), fast_decay_o is high for the first 8·(m+1)−1 off-time cycles and slow_decay_o for the rest. Here m is fast_code_i read as unsigned. The two flags are never high together, and fast decay never follows slow decay within one off-time.
- R7: In mixed mode, when 8·(m+1)−1 is at least the off-time, fast_decay_o is high for the entire off-time.
- R8: With slow_only_i = 1, slow_decay_o is high for the entire off-time, whatever fast_code_i holds.
- R9: When the off-time expires with drive_req_i still high, src_en_o and blank_o rise together on the next cycle, and a full blanking window follows.
- R10: trip_i has no effect during the off-time: its length and split stay the same when trip_i is held high.
- R11: One cycle after drive_req_i is sampled low, all four outputs are low, whatever phase was in progress.
- R12: blank_code_i is captured when a blanking window starts. off_code_i, fast_code_i and slow_only_i are captured when an off-time starts. Changing them later does not alter the window or off-time already under way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| drive_req_i | input | 1 | Drive request; low forces idle |
| trip_i | input | 1 | Current-trip comparator output |
| blank_code_i | input | BLANK_CODE_W | Blanking window code |
| off_code_i | input | OFF_W | Off-time code n |
| fast_code_i | input | FAST_W | Fast-decay code m |
| slow_only_i | input | 1 | 1 = slow decay only, 0 = mixed decay |
| src_en_o | output | 1 | Source side enabled (on-phase incl. blanking) |
| blank_o | output | 1 | Trip comparator masked |
| fast_decay_o | output | 1 | Off-time, fast-decay portion |
| slow_decay_o | output | 1 | Off-time, slow-decay portion |

## Verification
The bench builds the block with its default parameters: a 2-bit blanking code, a 5-bit off code, a 4-bit fast code and a scale of 8 cycles per step. With these values the full 255-cycle off-time and the 127-cycle fast stretch are both within reach. So are cases where the fast stretch is shorter than the off-time, equal to it and longer than it, which are the points where the split collapses to pure fast decay. The short codes also let the bench drive a trip that is held through blanking and the off-time, change configuration in the middle of a phase, and drop the request mid-phase, each within a few dozen cycles.

// File: rtl/chop_pkg.sv
package chop_pkg;

    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_BLANK = 2'd1,
        PH_ON    = 2'd2,
        PH_OFF   = 2'd3
    } phase_e;

    typedef struct packed {
        phase_e phase;
    } ctrl_state_t;

endpackage

// File: rtl/chop_blank_timer.sv
module chop_blank_timer #(
    parameter int CODE_W     = 2,
    parameter int BLANK_MIN  = 4,
    parameter int BLANK_STEP = 6
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic [CODE_W-1:0] code_i,
    output logic              active_o,
    output logic              last_o
);
    localparam int NCODES   = 1 << CODE_W;
    localparam int MAX_STEP = BLANK_STEP << (NCODES - 2);
    localparam int MAX_LEN  = (MAX_STEP > BLANK_MIN) ? MAX_STEP : BLANK_MIN;
    localparam int CNT_W    = $clog2(MAX_LEN + 1);

    // Window length per code: the smallest code uses the minimum,
    // every further code doubles the step length.
    logic [CNT_W-1:0] len_tab [NCODES];

    for (genvar c = 0; c < NCODES; c++) begin : g_len
        if (c == 0) begin : g_min
            assign len_tab[c] = CNT_W'(BLANK_MIN);
        end else begin : g_step
            assign len_tab[c] = CNT_W'(BLANK_STEP << (c - 1));
        end
    end

    typedef struct packed {
        logic             active;
        logic [CNT_W-1:0] cnt;
    } bt_state_t;

    bt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (start_i) begin
            s_d.active = 1'b1;
            s_d.cnt    = len_tab[code_i] - CNT_W'(1);
        end else if (s_q.active) begin
            if (s_q.cnt == '0) begin
                s_d.active = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.active;
    assign last_o   = s_q.active && (s_q.cnt == '0);

endmodule

// File: rtl/chop_off_timer.sv
module chop_off_timer #(
    parameter int OFF_W     = 5,
    parameter int FAST_W    = 4,
    parameter int UNIT_LOG2 = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic              clear_i,
    input  logic [OFF_W-1:0]  off_code_i,
    input  logic [FAST_W-1:0] fast_code_i,
    input  logic              slow_only_i,
    output logic              fast_o,
    output logic              slow_o,
    output logic              expire_o
);
    localparam int OFF_LEN_W  = OFF_W + UNIT_LOG2;
    localparam int FAST_LEN_W = FAST_W + UNIT_LOG2;
    localparam int CMP_W      = (OFF_LEN_W > FAST_LEN_W) ? OFF_LEN_W : FAST_LEN_W;

    typedef struct packed {
        logic                  active;
        logic                  mixed;
        logic [OFF_LEN_W-1:0]  el;
        logic [OFF_LEN_W-1:0]  last_el;
        logic [FAST_LEN_W-1:0] fast_len;
    } ot_state_t;

    ot_state_t s_d, s_q;

    // A length of unit*(code+1)-1 is the code followed by all-ones.
    logic [OFF_LEN_W-1:0]  off_len;
    logic [FAST_LEN_W-1:0] fast_len;
    logic [CMP_W-1:0]      el_ext;
    logic [CMP_W-1:0]      fast_ext;
    logic                  in_fast;

    assign off_len  = {off_code_i, {UNIT_LOG2{1'b1}}};
    assign fast_len = {fast_code_i, {UNIT_LOG2{1'b1}}};

    always_comb begin
        s_d = s_q;
        if (clear_i) begin
            s_d = '0;
        end else if (start_i) begin
            s_d.active   = 1'b1;
            s_d.mixed    = !slow_only_i;
            s_d.el       = '0;
            s_d.last_el  = off_len - OFF_LEN_W'(1);
            s_d.fast_len = fast_len;
        end else if (s_q.active) begin
            if (s_q.el == s_q.last_el) begin
                s_d.active = 1'b0;
                s_d.el     = '0;
            end else begin
                s_d.el = s_q.el + OFF_LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign el_ext   = CMP_W'(s_q.el);
    assign fast_ext = CMP_W'(s_q.fast_len);
    assign in_fast  = s_q.active && s_q.mixed && (el_ext < fast_ext);

    assign fast_o   = in_fast;
    assign slow_o   = s_q.active && !in_fast;
    assign expire_o = s_q.active && (s_q.el == s_q.last_el);

endmodule

// File: rtl/chop_phase_ctrl.sv
module chop_phase_ctrl
    import chop_pkg::*;
(
    input  logic   clk_i,
    input  logic   rst_ni,
    input  logic   drive_req_i,
    input  logic   trip_i,
    input  logic   blank_last_i,
    input  logic   off_expire_i,
    output phase_e phase_o,
    output logic   blank_start_o,
    output logic   off_start_o,
    output logic   clear_o
);
    ctrl_state_t s_d, s_q;

    always_comb begin
        s_d           = s_q;
        blank_start_o = 1'b0;
        off_start_o   = 1'b0;
        clear_o       = 1'b0;
        if (!drive_req_i) begin
            s_d.phase = PH_IDLE;
            clear_o   = 1'b1;
        end else begin
            unique case (s_q.phase)
                PH_IDLE: begin
                    s_d.phase     = PH_BLANK;
                    blank_start_o = 1'b1;
                end
                PH_BLANK: begin
                    if (blank_last_i) begin
                        s_d.phase = PH_ON;
                    end
                end
                PH_ON: begin
                    if (trip_i) begin
                        s_d.phase   = PH_OFF;
                        off_start_o = 1'b1;
                    end
                end
                PH_OFF: begin
                    if (off_expire_i) begin
                        s_d.phase     = PH_BLANK;
                        blank_start_o = 1'b1;
                    end
                end
                default: s_d.phase = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q.phase <= PH_IDLE;
        end else begin
            s_q <= s_d;
        end
    end

    assign phase_o = s_q.phase;

endmodule

// File: rtl/chop_pwm_timer.sv
module chop_pwm_timer
    import chop_pkg::*;
#(
    parameter int BLANK_CODE_W = 2,
    parameter int BLANK_MIN    = 4,
    parameter int BLANK_STEP   = 6,
    parameter int OFF_W        = 5,
    parameter int FAST_W       = 4,
    parameter int UNIT_LOG2    = 3
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic                    drive_req_i,
    input  logic                    trip_i,
    input  logic [BLANK_CODE_W-1:0] blank_code_i,
    input  logic [OFF_W-1:0]        off_code_i,
    input  logic [FAST_W-1:0]       fast_code_i,
    input  logic                    slow_only_i,
    output logic                    src_en_o,
    output logic                    blank_o,
    output logic                    fast_decay_o,
    output logic                    slow_decay_o
);
    phase_e phase;
    logic   blank_start;
    logic   off_start;
    logic   clear;
    logic   blank_active;
    logic   blank_last;
    logic   off_expire;

    chop_phase_ctrl u_ctrl (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .drive_req_i  (drive_req_i),
        .trip_i       (trip_i),
        .blank_last_i (blank_last),
        .off_expire_i (off_expire),
        .phase_o      (phase),
        .blank_start_o(blank_start),
        .off_start_o  (off_start),
        .clear_o      (clear)
    );

    chop_blank_timer #(
        .CODE_W    (BLANK_CODE_W),
        .BLANK_MIN (BLANK_MIN),
        .BLANK_STEP(BLANK_STEP)
    ) u_blank (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .start_i (blank_start),
        .clear_i (clear),
        .code_i  (blank_code_i),
        .active_o(blank_active),
        .last_o  (blank_last)
    );

    chop_off_timer #(
        .OFF_W    (OFF_W),
        .FAST_W   (FAST_W),
        .UNIT_LOG2(UNIT_LOG2)
    ) u_off (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (off_start),
        .clear_i    (clear),
        .off_code_i (off_code_i),
        .fast_code_i(fast_code_i),
        .slow_only_i(slow_only_i),
        .fast_o     (fast_decay_o),
        .slow_o     (slow_decay_o),
        .expire_o   (off_expire)
    );

    assign src_en_o = (phase == PH_BLANK) || (phase == PH_ON);
    assign blank_o  = blank_active;

endmodule

// File: rtl/chop_pwm_timer_chk.sv
module chop_pwm_timer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic drive_req_i,
    input logic trip_i,
    input logic src_en_o,
    input logic blank_o,
    input logic fast_decay_o,
    input logic slow_decay_o
);
    p_blank_in_drive_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        blank_o |-> src_en_o);

    p_exclusive_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({src_en_o, fast_decay_o, slow_decay_o}));

    p_blank_ignores_trip_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_req_i && blank_o && trip_i) |=> src_en_o);

    p_trip_ends_on_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_req_i && src_en_o && !blank_o && trip_i)
            |=> (!src_en_o && (fast_decay_o || slow_decay_o)));

    p_slow_tail_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_req_i && slow_decay_o) |=> !fast_decay_o);

    p_rearm_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drive_req_i && (fast_decay_o || slow_decay_o))
            |=> (fast_decay_o || slow_decay_o || blank_o));

    p_release_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !drive_req_i |=> !(src_en_o || blank_o || fast_decay_o || slow_decay_o));

endmodule

bind chop_pwm_timer chop_pwm_timer_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .drive_req_i (drive_req_i),
    .trip_i      (trip_i),
    .src_en_o    (src_en_o),
    .blank_o     (blank_o),
    .fast_decay_o(fast_decay_o),
    .slow_decay_o(slow_decay_o)
);

// File: tb/tb_chop_pwm_timer.sv
`timescale 1ns/1ps
module tb_chop_pwm_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       req;
    logic       trip;
    logic [1:0] bcode;
    logic [4:0] ocode;
    logic [3:0] fcode;
    logic       slow_only;
    logic       src_en, blank, fast, slow;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    chop_pwm_timer dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .drive_req_i (req),
        .trip_i      (trip),
        .blank_code_i(bcode),
        .off_code_i  (ocode),
        .fast_code_i (fcode),
        .slow_only_i (slow_only),
        .src_en_o    (src_en),
        .blank_o     (blank),
        .fast_decay_o(fast),
        .slow_decay_o(slow)
    );

    // blank code, off code, fast code, slow_only, blank len, off len, fast len
    localparam int VEC [8][7] = '{
        '{0,  0,  0, 0,  4,   7,   7},
        '{1,  3,  1, 0,  6,  31,  15},
        '{2,  7, 15, 0, 12,  63,  63},
        '{3, 31, 15, 0, 24, 255, 127},
        '{1,  5,  2, 1,  6,  47,   0},
        '{0,  1,  9, 1,  4,  15,   0},
        '{2,  2,  0, 0, 12,  23,   7},
        '{3, 10,  3, 0, 24,  87,  31}
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic count_blank(output int n);
        n = 0;
        while (blank && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic measure_off(output int t, output int f, output int s, output int both);
        t = 0; f = 0; s = 0; both = 0;
        while ((fast || slow) && t < 1000) begin
            t++;
            if (fast) f++;
            if (slow) s++;
            if (fast && slow) both++;
            @(negedge clk);
        end
    endtask

    task automatic run_vec(input int bc, input int oc, input int fc, input int so,
                           input int eb, input int eo, input int ef, input bit hold_trip);
        int n, t, f, s, both;
        string ftag;
        ftag = (so != 0) ? "R8" : ((ef == eo) ? "R7" : "R6");
        bcode = 2'(bc); ocode = 5'(oc); fcode = 4'(fc); slow_only = so[0];
        req = 1'b1; trip = hold_trip;
        @(negedge clk);
        check(src_en && blank, "R2 start", {src_en, blank}, 3);
        count_blank(n);
        check(n == eb, hold_trip ? "R3 blank length" : "R2 blank length", n, eb);
        check(src_en && !fast && !slow, "R4 on-phase", src_en, 1);
        trip = 1'b1;
        @(negedge clk);
        if (!hold_trip) trip = 1'b0;
        check(!src_en, "R4 source off", src_en, 0);
        measure_off(t, f, s, both);
        check(t == eo, hold_trip ? "R10 off length" : "R5 off length", t, eo);
        check(f == ef, ftag, f, ef);
        check(s == eo - ef, "R6 slow part", s, eo - ef);
        check(both == 0, "R6 overlap", both, 0);
        check(blank && src_en, "R9 rearm", {src_en, blank}, 3);
        count_blank(n);
        check(n == eb, "R9 blank length", n, eb);
        req = 1'b0; trip = 1'b0;
        @(negedge clk);
        check(!(src_en || blank || fast || slow), "R11 release",
              {src_en, blank, fast, slow}, 0);
    endtask

    initial begin : watchdog
        int cyc;
        cyc = 0;
        while (cyc < 100000 && !done) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk + 1, n_fail);
            $finish;
        end
    end

    initial begin : main
        int n, t, f, s, both;
        rst_n = 1'b0; req = 1'b1; trip = 1'b1;
        bcode = 2'd0; ocode = '0; fcode = '0; slow_only = 1'b0;
        repeat (3) @(negedge clk);
        check(!(src_en || blank || fast || slow), "R1 in reset",
              {src_en, blank, fast, slow}, 0);
        req = 1'b0; trip = 1'b0;
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(!(src_en || blank || fast || slow), "R1 after reset",
              {src_en, blank, fast, slow}, 0);

        // Table walk: plain trips, then trip held high through all phases
        for (int i = 0; i < 8; i++) begin
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                    VEC[i][4], VEC[i][5], VEC[i][6], 1'b0);
        end
        for (int i = 0; i < 8; i += 3) begin
            run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3],
                    VEC[i][4], VEC[i][5], VEC[i][6], 1'b1);
        end

        // R12: blank code changed inside a window
        bcode = 2'd3; req = 1'b1;
        @(negedge clk);
        bcode = 2'd0;
        count_blank(n);
        check(n == 24, "R12 blank captured", n, 24);

        // R12: off configuration changed inside an off-time
        ocode = 5'd3; fcode = 4'd1; slow_only = 1'b0;
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        ocode = 5'd31; fcode = 4'd15; slow_only = 1'b1;
        measure_off(t, f, s, both);
        check(t == 31, "R12 off captured", t, 31);
        check(f == 15, "R12 fast captured", f, 15);

        // R11: request dropped in the middle of an off-time
        ocode = 5'd4; slow_only = 1'b0;
        count_blank(n);
        trip = 1'b1;
        @(negedge clk);
        trip = 1'b0;
        repeat (3) @(negedge clk);
        check(fast, "R6 mid-off fast", fast, 1);
        req = 1'b0;
        @(negedge clk);
        check(!(src_en || blank || fast || slow), "R11 drop in off",
              {src_en, blank, fast, slow}, 0);

        // R11: request dropped inside a blanking window, then restarted
        bcode = 2'd2; req = 1'b1;
        repeat (3) @(negedge clk);
        req = 1'b0;
        @(negedge clk);
        check(!(src_en || blank), "R11 drop in blank", {src_en, blank}, 0);
        bcode = 2'd1; req = 1'b1;
        @(negedge clk);
        count_blank(n);
        check(n == 6, "R2 fresh window", n, 6);
        req = 1'b0;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule